// File: doc/BRIEF.md
# Flash Erase and Program Unlock Controller

This block sits between an 8-bit CPU's special-function-register bus and an on-chip flash array. It guards destructive flash operations. An erase starts only when the CPU writes an exact command byte to the erase command register, and only after a matching arming write. A page erase must follow a write of the page number. A mass erase must follow the setting of a mass-erase enable bit, and it also needs the debug port enable input. Each arming write is consumed by the erase that uses it.

Accepted erases appear as one-clock pulses on separate page-erase and mass-erase outputs. The latched page number is valid in the same cycle. The block also steers the CPU's external-data byte writes. They go either to data RAM or, when the program-write enable bit is set, to the flash array at the write address. That enable clears itself after each byte sent to flash. The CPU cannot change it while the global interrupt enable is set.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: After reset, both erase pulses are low, the program-write enable reads 0, the page number reads 0, and no page or mass arming is held.
- R2: Writing 0x55 to the erase command register while page arming is held and busy is low produces a page-erase pulse in the next clock cycle. In that cycle, erase_page equals bits 7:1 of the last byte written to the page register.
- R3: Writing 0xAA to the erase command register while the mass-erase enable (control register bit 1) is 1, debug enable is high and busy is low produces a mass-erase pulse in the next clock cycle.
- R4: A 0xAA command issued while debug enable is low produces no pulse and leaves the mass-erase enable set.
- R5: A byte other than 0x55 or 0xAA written to the erase command register produces no pulse and leaves all arming unchanged.
- R6: An accepted erase consumes its arming. A repeat of the same command without a new arming write produces no pulse.
- R7: A command written while busy is high produces no pulse and consumes no arming.
- R8: While the program-write enable is 0, an external-data write appears on the RAM write port. While it is 1, the write appears on the flash write port with the same address and data. The two ports are never active together.
- R9: The program-write enable clears in the clock edge that accepts a flash byte write.
- R10: A control-register write changes the program-write enable (bit 0) only while the interrupt enable input is low. Bit 1 of the same write always updates the mass-erase enable.
- R11: Each erase pulse lasts exactly one clock cycle, and the page-erase and mass-erase pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| irq_global_en | input | 1 | CPU global interrupt enable |
| dbg_port_en | input | 1 | Debug port enabled |
| flash_busy | input | 1 | Flash array busy |
| xdata_wr | input | 1 | External-data byte write strobe |
| xdata_addr | input | 16 | External-data write address |
| xdata_wdata | input | 8 | External-data write byte |
| page_erase | output | 1 | One-cycle page-erase request |
| mass_erase | output | 1 | One-cycle mass-erase request |
| erase_page | output | 7 | Page number for page erase |
| prog_wr_en | output | 1 | Current program-write enable |
| flash_wr | output | 1 | Flash byte write strobe |
| flash_addr | output | 16 | Flash byte address |
| flash_wdata | output | 8 | Flash byte data |
| xram_wr | output | 1 | Data RAM write strobe |
| xram_addr | output | 16 | Data RAM address |
| xram_wdata | output | 8 | Data RAM write byte |

## Verification
The assertions assume that the CPU never issues a register write and an external-data write in the same cycle. One-cycle pulse widths and stable enables rely on that assumption. The stimulus performs one bus operation per task call and drops every strobe between calls, so the two kinds of write cannot overlap. The random phase draws busy, debug enable and interrupt enable independently on each operation. This covers rejected commands in every combination without breaking the single-operation rule.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;

  localparam logic [7:0] CMD_PAGE_ERASE = 8'h55;
  localparam logic [7:0] CMD_MASS_ERASE = 8'hAA;

  typedef enum logic [1:0] {
    ERASE_NONE = 2'd0,
    ERASE_PAGE = 2'd1,
    ERASE_MASS = 2'd2
  } erase_kind_e;

  // Classify a byte written to the erase command register.
  function automatic erase_kind_e classify_cmd(input logic [7:0] value);
    if (value == CMD_PAGE_ERASE) return ERASE_PAGE;
    if (value == CMD_MASS_ERASE) return ERASE_MASS;
    return ERASE_NONE;
  endfunction

  // Acceptance rule for a page erase.
  function automatic logic page_ok(input logic armed, input logic busy);
    return armed && !busy;
  endfunction

  // Acceptance rule for a mass erase.
  function automatic logic mass_ok(input logic enabled, input logic dbg,
                                   input logic busy);
    return enabled && dbg && !busy;
  endfunction

endpackage

// File: rtl/flash_arm_regs.sv
module flash_arm_regs #(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_wr,
  input  logic [PAGE_W-1:0] page_data,
  input  logic              ctrl_wr,
  input  logic              ctrl_mass_bit,
  input  logic              ctrl_pwe_bit,
  input  logic              irq_en,
  input  logic              page_consume,
  input  logic              mass_consume,
  input  logic              flash_byte_done,
  output logic [PAGE_W-1:0] page_num,
  output logic              page_armed,
  output logic              mass_en,
  output logic              pwe
);

  // Page number and its single-use arming flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_num   <= '0;
      page_armed <= 1'b0;
    end else if (page_wr) begin
      page_num   <= page_data;
      page_armed <= 1'b1;
    end else if (page_consume) begin
      page_armed <= 1'b0;
    end
  end

  // Mass-erase enable: consumed by an accepted mass erase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mass_en <= 1'b0;
    end else if (mass_consume) begin
      mass_en <= 1'b0;
    end else if (ctrl_wr) begin
      mass_en <= ctrl_mass_bit;
    end
  end

  // Program-write enable: locked while interrupts are on, self-clearing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwe <= 1'b0;
    end else if (flash_byte_done) begin
      pwe <= 1'b0;
    end else if (ctrl_wr && !irq_en) begin
      pwe <= ctrl_pwe_bit;
    end
  end

endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_unlock_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              page_armed,
  input  logic              mass_en,
  input  logic              dbg_en,
  input  logic              busy,
  output logic              page_accept,
  output logic              mass_accept,
  output logic              page_pulse,
  output logic              mass_pulse
);

  erase_kind_e kind;

  always_comb begin
    kind        = cmd_wr ? classify_cmd(cmd_data[7:0]) : ERASE_NONE;
    page_accept = (kind == ERASE_PAGE) && page_ok(page_armed, busy);
    mass_accept = (kind == ERASE_MASS) && mass_ok(mass_en, dbg_en, busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_pulse <= 1'b0;
      mass_pulse <= 1'b0;
    end else begin
      page_pulse <= page_accept;
      mass_pulse <= mass_accept;
    end
  end

endmodule

// File: rtl/flash_xdata_steer.sv
module flash_xdata_steer #(
  parameter int XADDR_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic               pwe,
  input  logic               wr,
  input  logic [XADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               flash_wr,
  output logic [XADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0]  flash_wdata,
  output logic               xram_wr,
  output logic [XADDR_W-1:0] xram_addr,
  output logic [DATA_W-1:0]  xram_wdata
);

  always_comb begin
    flash_wr    = wr && pwe;
    xram_wr     = wr && !pwe;
    flash_addr  = addr;
    flash_wdata = wdata;
    xram_addr   = addr;
    xram_wdata  = wdata;
  end

endmodule

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl #(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter int         XADDR_W   = 16,
  parameter int         PAGE_W    = 7,
  parameter logic [7:0] ERASE_REG = 8'h94,
  parameter logic [7:0] CTRL_REG  = 8'hB2,
  parameter logic [7:0] PAGE_REG  = 8'hB7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sfr_wr,
  input  logic [ADDR_W-1:0]  sfr_addr,
  input  logic [DATA_W-1:0]  sfr_wdata,
  input  logic               irq_global_en,
  input  logic               dbg_port_en,
  input  logic               flash_busy,
  input  logic               xdata_wr,
  input  logic [XADDR_W-1:0] xdata_addr,
  input  logic [DATA_W-1:0]  xdata_wdata,
  output logic               page_erase,
  output logic               mass_erase,
  output logic [PAGE_W-1:0]  erase_page,
  output logic               prog_wr_en,
  output logic               flash_wr,
  output logic [XADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0]  flash_wdata,
  output logic               xram_wr,
  output logic [XADDR_W-1:0] xram_addr,
  output logic [DATA_W-1:0]  xram_wdata
);

  localparam int PAGE_LSB = 1;
  localparam int PAGE_MSB = PAGE_LSB + PAGE_W - 1;

  // Named internal events for the checker.
  logic erase_reg_wr, ctrl_reg_wr, page_reg_wr;
  logic page_accept, mass_accept;
  logic page_armed, mass_en;

  assign erase_reg_wr = sfr_wr && (sfr_addr == ADDR_W'(ERASE_REG));
  assign ctrl_reg_wr  = sfr_wr && (sfr_addr == ADDR_W'(CTRL_REG));
  assign page_reg_wr  = sfr_wr && (sfr_addr == ADDR_W'(PAGE_REG));

  flash_arm_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .page_wr         (page_reg_wr),
    .page_data       (sfr_wdata[PAGE_MSB:PAGE_LSB]),
    .ctrl_wr         (ctrl_reg_wr),
    .ctrl_mass_bit   (sfr_wdata[1]),
    .ctrl_pwe_bit    (sfr_wdata[0]),
    .irq_en          (irq_global_en),
    .page_consume    (page_accept),
    .mass_consume    (mass_accept),
    .flash_byte_done (flash_wr),
    .page_num        (erase_page),
    .page_armed      (page_armed),
    .mass_en         (mass_en),
    .pwe             (prog_wr_en)
  );

  flash_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (erase_reg_wr),
    .cmd_data    (sfr_wdata),
    .page_armed  (page_armed),
    .mass_en     (mass_en),
    .dbg_en      (dbg_port_en),
    .busy        (flash_busy),
    .page_accept (page_accept),
    .mass_accept (mass_accept),
    .page_pulse  (page_erase),
    .mass_pulse  (mass_erase)
  );

  flash_xdata_steer #(.XADDR_W(XADDR_W), .DATA_W(DATA_W)) u_steer (
    .pwe         (prog_wr_en),
    .wr          (xdata_wr),
    .addr        (xdata_addr),
    .wdata       (xdata_wdata),
    .flash_wr    (flash_wr),
    .flash_addr  (flash_addr),
    .flash_wdata (flash_wdata),
    .xram_wr     (xram_wr),
    .xram_addr   (xram_addr),
    .xram_wdata  (xram_wdata)
  );

endmodule

// File: rtl/flash_unlock_checker.sv
module flash_unlock_checker #(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter logic [7:0] ERASE_REG = 8'h94,
  parameter logic [7:0] CTRL_REG  = 8'hB2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sfr_wr,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic              irq_global_en,
  input logic              dbg_port_en,
  input logic              flash_busy,
  input logic              xdata_wr,
  input logic              page_erase,
  input logic              mass_erase,
  input logic              prog_wr_en,
  input logic              flash_wr,
  input logic              xram_wr
);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(page_erase && mass_erase));

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (page_erase || mass_erase) |=> !(page_erase || mass_erase));

  a_r2_page_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_erase) |-> $past(sfr_wr && sfr_addr == ADDR_W'(ERASE_REG)
                                && sfr_wdata == DATA_W'(8'h55)));

  a_r3_mass_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mass_erase) |-> $past(sfr_wr && sfr_addr == ADDR_W'(ERASE_REG)
                                && sfr_wdata == DATA_W'(8'hAA)));

  a_r4_mass_needs_dbg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mass_erase) |-> $past(dbg_port_en));

  a_r7_not_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(page_erase) || $rose(mass_erase)) |-> !$past(flash_busy));

  a_r8_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_wr && xram_wr));

  a_r9_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flash_wr |=> !prog_wr_en);

  a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_wr && sfr_addr == ADDR_W'(CTRL_REG) && irq_global_en && !xdata_wr)
      |=> $stable(prog_wr_en));

endmodule

bind flash_unlock_ctrl flash_unlock_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_REG(ERASE_REG), .CTRL_REG(CTRL_REG)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sfr_wr        (sfr_wr),
  .sfr_addr      (sfr_addr),
  .sfr_wdata     (sfr_wdata),
  .irq_global_en (irq_global_en),
  .dbg_port_en   (dbg_port_en),
  .flash_busy    (flash_busy),
  .xdata_wr      (xdata_wr),
  .page_erase    (page_erase),
  .mass_erase    (mass_erase),
  .prog_wr_en    (prog_wr_en),
  .flash_wr      (flash_wr),
  .xram_wr       (xram_wr)
);

// File: tb/flash_unlock_ctrl_bench.sv
module flash_unlock_ctrl_bench;

  localparam logic [7:0] A_ERASE = 8'h94;
  localparam logic [7:0] A_CTRL  = 8'hB2;
  localparam logic [7:0] A_PAGE  = 8'hB7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_addr = '0;
  logic [7:0]  sfr_wdata = '0;
  logic        irq_global_en = 1'b0;
  logic        dbg_port_en = 1'b0;
  logic        flash_busy = 1'b0;
  logic        xdata_wr = 1'b0;
  logic [15:0] xdata_addr = '0;
  logic [7:0]  xdata_wdata = '0;
  logic        page_erase, mass_erase, prog_wr_en, flash_wr, xram_wr;
  logic [6:0]  erase_page;
  logic [15:0] flash_addr, xram_addr;
  logic [7:0]  flash_wdata, xram_wdata;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // Bench model of the arming state.
  bit       m_armed = 1'b0;
  bit [6:0] m_page  = '0;
  bit       m_mass  = 1'b0;
  bit       m_pwe   = 1'b0;

  always #4 clk = ~clk;

  flash_unlock_ctrl u_flash_unlock_ctrl (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .irq_global_en(irq_global_en),
    .dbg_port_en(dbg_port_en), .flash_busy(flash_busy), .xdata_wr(xdata_wr),
    .xdata_addr(xdata_addr), .xdata_wdata(xdata_wdata),
    .page_erase(page_erase), .mass_erase(mass_erase), .erase_page(erase_page),
    .prog_wr_en(prog_wr_en), .flash_wr(flash_wr), .flash_addr(flash_addr),
    .flash_wdata(flash_wdata), .xram_wr(xram_wr), .xram_addr(xram_addr),
    .xram_wdata(xram_wdata)
  );

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic bit want_page(input bit [7:0] d, input bit busy);
    return d == 8'h55 && m_armed && !busy;
  endfunction

  function automatic bit want_mass(input bit [7:0] d, input bit busy,
                                   input bit dbg);
    return d == 8'hAA && m_mass && dbg && !busy;
  endfunction

  // One register write; check the pulse cycle and the cycle after.
  task automatic do_sfr(input logic [7:0] a, input logic [7:0] d);
    bit ep = 1'b0;
    bit em = 1'b0;
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    if (a == A_ERASE) begin
      ep = want_page(d, flash_busy);
      em = want_mass(d, flash_busy, dbg_port_en);
      if (ep) m_armed = 1'b0;
      if (em) m_mass  = 1'b0;
    end else if (a == A_PAGE) begin
      m_page = d[7:1]; m_armed = 1'b1;
    end else if (a == A_CTRL) begin
      m_mass = d[1];
      if (!irq_global_en) m_pwe = d[0];
    end
    @(negedge clk);
    sfr_wr = 1'b0;
    check("R2 page pulse", {31'd0, page_erase}, {31'd0, ep});
    check("R3 mass pulse", {31'd0, mass_erase}, {31'd0, em});
    if (ep) check("R2 page number", {25'd0, erase_page}, {25'd0, m_page});
    check("R10 pwe state", {31'd0, prog_wr_en}, {31'd0, m_pwe});
    @(negedge clk);
    check("R11 pulse width", {30'd0, page_erase, mass_erase}, 32'd0);
  endtask

  // One external-data write; check steering, then the self-clear.
  task automatic do_xdata(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    xdata_wr = 1'b1; xdata_addr = a; xdata_wdata = d;
    #1;
    check("R8 flash port", {31'd0, flash_wr}, {31'd0, m_pwe});
    check("R8 ram port", {31'd0, xram_wr}, {31'd0, !m_pwe});
    if (m_pwe) check("R8 flash addr/data", {8'd0, flash_addr, flash_wdata}, {8'd0, a, d});
    else       check("R8 ram addr/data", {8'd0, xram_addr, xram_wdata}, {8'd0, a, d});
    @(negedge clk);
    xdata_wr = 1'b0;
    m_pwe = 1'b0;
    check("R9 pwe cleared", {31'd0, prog_wr_en}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pulses", {30'd0, page_erase, mass_erase}, 32'd0);
    check("R1 reset pwe", {31'd0, prog_wr_en}, 32'd0);
    check("R1 reset page", {25'd0, erase_page}, 32'd0);
    rst_n = 1'b1;
    // R1: no arming after reset, so both commands are refused.
    dbg_port_en = 1'b1;
    do_sfr(A_ERASE, 8'h55);
    do_sfr(A_ERASE, 8'hAA);
    // R2 at the top page, then R6 repeat refused.
    do_sfr(A_PAGE, 8'hFE);
    do_sfr(A_ERASE, 8'h55);
    do_sfr(A_ERASE, 8'h55);
    // R2 page 0 boundary.
    do_sfr(A_PAGE, 8'h01);
    do_sfr(A_ERASE, 8'h55);
    // R4 without debug, enable kept; R3 then succeeds; R6 repeat refused.
    dbg_port_en = 1'b0;
    do_sfr(A_CTRL, 8'h02);
    do_sfr(A_ERASE, 8'hAA);
    dbg_port_en = 1'b1;
    do_sfr(A_ERASE, 8'hAA);
    do_sfr(A_ERASE, 8'hAA);
    // R5 wrong pattern keeps arming.
    do_sfr(A_PAGE, 8'h2A);
    do_sfr(A_ERASE, 8'h54);
    do_sfr(A_ERASE, 8'h00);
    do_sfr(A_ERASE, 8'h55);
    // R7 busy refuses without consuming.
    do_sfr(A_PAGE, 8'h80);
    flash_busy = 1'b1;
    do_sfr(A_ERASE, 8'h55);
    flash_busy = 1'b0;
    do_sfr(A_ERASE, 8'h55);
    // R10 locked with interrupts on; R8 to RAM.
    irq_global_en = 1'b1;
    do_sfr(A_CTRL, 8'h01);
    do_xdata(16'h1234, 8'h5A);
    irq_global_en = 1'b0;
    do_sfr(A_CTRL, 8'h01);
    // R8 to flash, R9 self-clear, next goes to RAM.
    do_xdata(16'hFFFF, 8'hC3);
    do_xdata(16'h0000, 8'h3C);
    // Random phase with a fixed seed.
    void'($urandom(32'h5EED1));
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 5);
      flash_busy    = ($urandom_range(0, 4) == 0);
      dbg_port_en   = ($urandom_range(0, 2) != 0);
      irq_global_en = ($urandom_range(0, 2) == 0);
      case (op)
        0: do_sfr(A_PAGE, 8'($urandom));
        1: do_sfr(A_CTRL, 8'($urandom_range(0, 3)));
        2: do_sfr(A_ERASE, ($urandom_range(0, 1) != 0) ? 8'h55 : 8'hAA);
        3: do_sfr(A_ERASE, 8'($urandom));
        4: do_xdata(16'($urandom), 8'($urandom));
        default: do_sfr(8'($urandom), 8'($urandom));
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule